// File: doc/BRIEF.md
# Direct-Mapped Cache Line Store

This block is the storage half of a small direct-mapped cache of 16 lines. Each line holds four 16-bit words. A separate handshake controller steps through its states, and this block follows the state code and the fill counter that controller drives. From them it derives a 2-bit next-value select for each of four word registers, and the write strobe for a 74-bit line memory. Each memory entry holds a 10-bit tag and the four words of the line. A 16-bit valid vector records which lines hold real contents. Hit and miss are derived from that vector together with the tag read back from the memory.

A line is assembled in the word registers before it reaches the memory. On a fill, one word arrives from off-chip memory at each count value. On a write hit, the addressed word takes the processor's write data and the other three are copied from the resident line. The whole entry, tag and all four words, is then written in one cycle in the completion state.

The controller state codes are:

| Code | Name | Meaning |
|------|------|---------|
| 0 | IDLE | waiting for an access |
| 1 | RD_REQ | read request issued |
| 2 | FILL_WAIT | waiting for a fill word |
| 3 | FILL_TAKE | fill word present |
| 4 | WR_START | write begins |
| 5 | WR_DATA | write in progress |
| 6 | WR_ACK | write in progress |
| 7 | WR_DONE | write in progress |
| 8 | COMMIT | line written back |

The transitions are as follows:

| Access | State sequence |
|--------|----------------|
| Read hit | IDLE only |
| Read miss | IDLE → RD_REQ, then FILL_WAIT → FILL_TAKE four times, then COMMIT → IDLE |
| Write hit | IDLE → WR_START → WR_DATA → WR_ACK → WR_DONE → COMMIT → IDLE |
| Write miss | as a write hit up to WR_DONE, then four FILL_WAIT → FILL_TAKE pairs, then COMMIT → IDLE |

Top module: `cache_line_store`

## Requirements
- R1: While rst_n is low, every valid bit clears. Afterwards `hit` is 0 for every address until a line has been committed, and `miss` is 1 whenever `cpu_req` is 1.
- R2: The line index is `cpu_addr[5:2]` and the tag is `cpu_addr[15:6]`. Word k of a line is selected by `cpu_addr[1:0]` = k.
- R3: `hit` is 1 exactly when the valid bit of the indexed line is set and its stored tag equals `cpu_addr[15:6]`. `miss` is `cpu_req` and not `hit`, so `miss` is 0 when `cpu_req` is 0.
- R4: Outside COMMIT (state 8), `line_data` shows the stored words of the indexed line, with word k in bits [16k+15:16k]. During COMMIT it shows the assembled word registers.
- R5: At a clock edge in FILL_TAKE (state 3) with `fill_cnt` = k, word register k loads `mem_rdata` and the other registers keep their values.
- R6: At a clock edge in WR_START (state 4) with `hit` set, the register selected by `cpu_addr[1:0]` loads `cpu_wdata` and the other three load the stored words of the line. With `hit` clear, all registers are kept.
- R7: At a clock edge in COMMIT, the indexed entry receives the current tag and the four registers, and its valid bit is set. No other state writes the memory or the valid bits.
- R8: A valid bit stays set until reset. Committing one line does not change any other line's contents or valid bit.
- R9: In states 0, 1, 2, 5, 6 and 7 all word registers are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset, clears valid bits and word registers |
| cpu_addr | input | 16 | processor address |
| cpu_wdata | input | 16 | processor write data |
| cpu_req | input | 1 | processor access active |
| mem_rdata | input | 16 | off-chip read data during a fill |
| ctl_state | input | 4 | controller state code |
| fill_cnt | input | 2 | number of the fill word being received |
| line_data | output | 64 | line contents: stored words, or assembled words during COMMIT |
| hit | output | 1 | indexed line is valid and its tag matches |
| miss | output | 1 | access active and not a hit |

## Verification
The hardest case to reach from the ports is a write hit whose merge must keep three resident words. It needs a line already committed at that index with the same tag. It also needs a commit afterwards, so that the merged line becomes visible. The random stimulus draws addresses from only three tags, so resident lines are revisited often. Each operation drives a full, legal controller sequence: reads that miss fill first, and writes that miss fill after the write states. A bench model of the tags, valid bits and words predicts `hit`, `miss` and `line_data` on every cycle. Directed cases before the random phase cover reset, an idle `cpu_req`, conflicting tags at one index and each word offset.

// File: rtl/cls_pkg.sv
package cls_pkg;

    typedef enum logic [3:0] {
        ST_IDLE      = 4'd0,
        ST_RD_REQ    = 4'd1,
        ST_FILL_WAIT = 4'd2,
        ST_FILL_TAKE = 4'd3,
        ST_WR_START  = 4'd4,
        ST_WR_DATA   = 4'd5,
        ST_WR_ACK    = 4'd6,
        ST_WR_DONE   = 4'd7,
        ST_COMMIT    = 4'd8
    } ctl_state_t;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_MEM  = 2'd1,
        SEL_CPU  = 2'd2,
        SEL_RAM  = 2'd3
    } word_sel_t;

endpackage

// File: rtl/cls_sel_ctrl.sv
module cls_sel_ctrl
    import cls_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            state_code,
    input  logic [OFF_W-1:0]      fill_cnt,
    input  logic [OFF_W-1:0]      word_off,
    input  logic                  line_hit,
    output word_sel_t [WORDS-1:0] word_sel,
    output logic                  commit_en
);

    ctl_state_t state;
    logic [WORDS-1:0] mem_pick;

    assign state = ctl_state_t'(state_code);

    always_comb begin
        word_sel  = '{default: SEL_HOLD};
        commit_en = 1'b0;
        unique case (state)
            ST_FILL_TAKE: begin
                for (int k = 0; k < WORDS; k++) begin
                    if (fill_cnt == OFF_W'(k)) word_sel[k] = SEL_MEM;
                end
            end
            ST_WR_START: begin
                if (line_hit) begin
                    for (int k = 0; k < WORDS; k++) begin
                        word_sel[k] = (word_off == OFF_W'(k)) ? SEL_CPU : SEL_RAM;
                    end
                end
            end
            ST_COMMIT: commit_en = 1'b1;
            ST_IDLE, ST_RD_REQ, ST_FILL_WAIT,
            ST_WR_DATA, ST_WR_ACK, ST_WR_DONE: ;
            default: ;
        endcase
    end

    always_comb begin
        for (int k = 0; k < WORDS; k++) mem_pick[k] = (word_sel[k] == SEL_MEM);
    end

    // R5
    one_fill_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_pick));

endmodule

// File: rtl/cls_word_reg.sv
module cls_word_reg
    import cls_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  word_sel_t         sel,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] cpu_word,
    input  logic [WORD_W-1:0] ram_word,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] q_next;

    always_comb begin
        unique case (sel)
            SEL_MEM:  q_next = mem_word;
            SEL_CPU:  q_next = cpu_word;
            SEL_RAM:  q_next = ram_word;
            default:  q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // R9
    hold_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == SEL_HOLD) |-> $stable(q));

endmodule

// File: rtl/cls_valid_bits.sv
module cls_valid_bits #(
    parameter int LINES = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [IDX_W-1:0] idx,
    output logic             idx_valid
);

    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      valid_q <= '0;
        else if (set_en) valid_q[idx] <= 1'b1;
    end

    assign idx_valid = valid_q[idx];

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(valid_q) & ~valid_q) == '0);

endmodule

// File: rtl/cls_line_ram.sv
module cls_line_ram #(
    parameter int LINES = 16,
    parameter int ENTRY_W = 74,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic               clk,
    input  logic               we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [ENTRY_W-1:0] wr_entry,
    output logic [ENTRY_W-1:0] rd_entry
);

    logic [ENTRY_W-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wr_entry;
    end

    assign rd_entry = mem[idx];

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store
    import cls_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int WORDS  = 4,
    parameter int LINES  = 16,
    localparam int OFF_W   = $clog2(WORDS),
    localparam int IDX_W   = $clog2(LINES),
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W  = WORD_W * WORDS,
    localparam int ENTRY_W = TAG_W + LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              cpu_req,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [3:0]        ctl_state,
    input  logic [OFF_W-1:0]  fill_cnt,
    output logic [LINE_W-1:0] line_data,
    output logic              hit,
    output logic              miss
);

    logic [OFF_W-1:0]      word_off;
    logic [IDX_W-1:0]      line_idx;
    logic [TAG_W-1:0]      addr_tag;
    logic [ENTRY_W-1:0]    rd_entry;
    logic [LINE_W-1:0]     asm_line;
    logic                  commit_en;
    logic                  idx_valid;
    word_sel_t [WORDS-1:0] word_sel;
    logic                  past_ok;

    assign word_off = cpu_addr[OFF_W-1:0];
    assign line_idx = cpu_addr[OFF_W +: IDX_W];
    assign addr_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    cls_sel_ctrl #(.WORDS(WORDS)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_code (ctl_state),
        .fill_cnt   (fill_cnt),
        .word_off   (word_off),
        .line_hit   (hit),
        .word_sel   (word_sel),
        .commit_en  (commit_en)
    );

    generate
        for (genvar k = 0; k < WORDS; k++) begin : g_word
            cls_word_reg #(.WORD_W(WORD_W)) u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .sel      (word_sel[k]),
                .mem_word (mem_rdata),
                .cpu_word (cpu_wdata),
                .ram_word (rd_entry[k*WORD_W +: WORD_W]),
                .q        (asm_line[k*WORD_W +: WORD_W])
            );
        end
    endgenerate

    cls_line_ram #(.LINES(LINES), .ENTRY_W(ENTRY_W)) u_ram (
        .clk      (clk),
        .we       (commit_en),
        .idx      (line_idx),
        .wr_entry ({addr_tag, asm_line}),
        .rd_entry (rd_entry)
    );

    cls_valid_bits #(.LINES(LINES)) u_valid (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (commit_en),
        .idx       (line_idx),
        .idx_valid (idx_valid)
    );

    assign hit       = idx_valid && (rd_entry[ENTRY_W-1 -: TAG_W] == addr_tag);
    assign miss      = cpu_req && !hit;
    assign line_data = commit_en ? asm_line : rd_entry[LINE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R7
    commit_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ctl_state) == ST_COMMIT && $stable(cpu_addr)) |-> hit);

    // R3
    idle_no_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !miss);

endmodule

// File: tb/cache_line_store_test.sv
module cache_line_store_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_req = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic [3:0]  ctl_state = 4'd0;
    logic [1:0]  fill_cnt = '0;
    logic [63:0] line_data;
    logic        hit;
    logic        miss;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic        m_valid [16];
    logic [9:0]  m_tag   [16];
    logic [63:0] m_data  [16];
    logic [63:0] m_regs;

    cache_line_store uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_req(cpu_req), .mem_rdata(mem_rdata), .ctl_state(ctl_state),
        .fill_cnt(fill_cnt), .line_data(line_data), .hit(hit), .miss(miss)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (addr %h state %0d)", rq, act, exp, cpu_addr, ctl_state);
        end
    endtask

    function automatic logic exp_hit(logic [15:0] a);
        return m_valid[a[5:2]] && (m_tag[a[5:2]] == a[15:6]);
    endfunction

    // one cycle: drive at negedge, check settled outputs, update the model at the edge
    task automatic step(logic [3:0] st, logic [1:0] cnt, logic [15:0] md);
        logic [3:0] ix;
        logic       h;
        @(negedge clk);
        ctl_state = st; fill_cnt = cnt; mem_rdata = md;
        #2;
        ix = cpu_addr[5:2];
        h  = exp_hit(cpu_addr);
        chk("R3 hit", 64'(hit), 64'(h));
        chk("R3 miss", 64'(miss), 64'(cpu_req && !h));
        if (st == 4'd8)       chk("R4 line during commit", line_data, m_regs);
        else if (m_valid[ix]) chk("R4 stored line", line_data, m_data[ix]);
        case (st)
            4'd3: m_regs[cnt*16 +: 16] = md;
            4'd4: if (h) begin
                for (int k = 0; k < 4; k++)
                    m_regs[k*16 +: 16] = (cpu_addr[1:0] == 2'(k)) ? cpu_wdata : m_data[ix][k*16 +: 16];
            end
            4'd8: begin
                m_tag[ix] = cpu_addr[15:6]; m_data[ix] = m_regs; m_valid[ix] = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic do_fill();
        for (int k = 0; k < 4; k++) begin
            step(4'd2, 2'(k), 16'($urandom));
            step(4'd3, 2'(k), 16'($urandom));
        end
    endtask

    task automatic do_read(logic [15:0] a);
        @(negedge clk); cpu_addr = a; cpu_req = 1'b1;
        if (exp_hit(a)) begin
            step(4'd0, 2'd0, 16'h0);
        end else begin
            step(4'd0, 2'd0, 16'h0);
            step(4'd1, 2'd0, 16'h0);
            do_fill();
            step(4'd8, 2'd0, 16'h0);
            step(4'd0, 2'd0, 16'h0);
        end
        @(negedge clk); cpu_req = 1'b0;
    endtask

    task automatic do_write(logic [15:0] a, logic [15:0] d);
        logic h;
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
        h = exp_hit(a);
        step(4'd0, 2'd0, 16'h0);
        step(4'd4, 2'd0, 16'($urandom));
        step(4'd5, 2'd1, 16'($urandom));
        step(4'd6, 2'd2, 16'($urandom));
        step(4'd7, 2'd3, 16'($urandom));
        if (!h) do_fill();
        step(4'd8, 2'd0, 16'h0);
        step(4'd0, 2'd0, 16'h0);
        @(negedge clk); cpu_req = 1'b0;
    endtask

    function automatic logic [15:0] rnd_addr();
        logic [9:0] tg;
        logic [31:0] r;
        r  = $urandom;
        tg = (r[1:0] == 2'd0) ? 10'h0A5 : (r[1:0] == 2'd1) ? 10'h3C1 : 10'h100;
        return {tg, r[7:4], r[9:8]};
    endfunction

    initial begin
        int unused;
        unused = $urandom(32'd41);
        for (int i = 0; i < 16; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
        m_regs = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing valid after reset, every access misses
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); cpu_addr = {10'h155, 4'(i), 2'd1}; cpu_req = 1'b1; #2;
            chk("R1 hit after reset", 64'(hit), 64'd0);
            chk("R1 miss after reset", 64'(miss), 64'd1);
        end
        // R3: miss stays low with no access active
        @(negedge clk); cpu_req = 1'b0; #2;
        chk("R3 miss idle", 64'(miss), 64'd0);

        // R5 R7: read-miss fill of index 5, then a read hit
        do_read({10'h0A5, 4'd5, 2'd2});
        @(negedge clk); cpu_req = 1'b1; #2;
        chk("R7 hit after commit", 64'(hit), 64'd1);
        // R2: same index, other tag misses; other index is still invalid
        @(negedge clk); cpu_addr = {10'h0A6, 4'd5, 2'd2}; #2;
        chk("R2 tag mismatch", 64'(hit), 64'd0);
        @(negedge clk); cpu_addr = {10'h0A5, 4'd6, 2'd2}; #2;
        chk("R8 neighbour invalid", 64'(hit), 64'd0);
        @(negedge clk); cpu_req = 1'b0;

        // R6: write hit at every offset keeps the other three words
        for (int k = 0; k < 4; k++) do_write({10'h0A5, 4'd5, 2'(k)}, 16'hA000 + 16'(k));
        @(negedge clk); cpu_addr = {10'h0A5, 4'd5, 2'd0}; #2;
        chk("R6 merged line", line_data, 64'hA003_A002_A001_A000);

        // R6 R9: write miss to a conflicting tag refills the whole line
        do_write({10'h3C1, 4'd5, 2'd3}, 16'h1234);
        do_read({10'h0A5, 4'd5, 2'd0});

        // R8 random mix
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[0]) do_read(rnd_addr());
            else      do_write(rnd_addr(), 16'(r >> 8));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule